// File: doc/BRIEF.md
# Protection-Domain Doorbell Write Decoder

This block watches a simple host write bus and turns writes that land on doorbell slots into one-cycle doorbell events. The address space is split into one 4 KB page per protection domain. Domain 0 belongs to the host and domains 1 to 31 belong to virtual machines. Inside a page, doorbells sit in 32-byte slots, and only the first dword of each slot is live. Each event reports a doorbell kind code, the domain that was written, and the fields unpacked from the data word. The unpacked fields are a queue number, a count, two flags and an auxiliary byte. The raw data word is reported as well.

A completion/event-queue doorbell whose reserved bits are not all zero is not executed. It raises an error pulse instead, and that pulse carries the domain and the queue number. A write that reaches a live doorbell dword without all four byte lanes enabled is dropped, and a saturating counter records it. Writes to reserved offsets, and to the unused dwords of a slot, produce nothing at all. The mailbox slot is forwarded untouched as a raw event.

The address is a byte address. Bits 16:12 select the domain and bits 11:0 give the offset in the page. Results appear one clock after the write is accepted.

Top module: `dbell_write_decode`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `ev_valid`, `err_valid`, `ign_count`, `ev_kind` and `ev_raw` are all zero.
- R2: A full write (`wr_be`=4'hF) to the first dword of a listed slot raises `ev_valid` for exactly one cycle, on the cycle after the write. Listed slots are offsets 0x040 to 0x160 in steps of 0x20. `ev_kind` is (offset−0x40)/0x20: 0 RDMA send, 1 storage WRB post, 2 Ethernet send, 3 RDMA receive, 4 default-PDU, 5 TPM receive, 6 Ethernet receive, 7 completion/event queue, 8 management ring, 9 mailbox. `ev_domain` is address bits 16:12, and `ev_raw` is the written data.
- R3: Only dword 0 of a slot is live. A write with address bits 4:2 nonzero gives no event, no error and no count. Address bits 1:0 are ignored.
- R4: Offsets below 0x040 or above 0x160 give no event, no error and no count, whatever the byte enables are.
- R5: Kinds 0, 2 and 8 use the send layout: `ev_qid`=data[10:0] and `ev_count`=data[29:16]. The flags and `ev_aux` are 0.
- R6: Kinds 3 and 6 use the receive layout: `ev_qid`=data[9:0], `ev_flag_a` (invalidate)=data[23] and `ev_count`=data[31:24]. `ev_flag_b` and `ev_aux` are 0.
- R7: Kind 7 uses the completion layout: `ev_qid`=data[9:0], `ev_flag_a` (rearm)=data[14], `ev_flag_b` (event)=data[15] and `ev_count`=data[28:16]. `ev_aux` is 0.
- R8: If a kind-7 full write has any of data[13:10] or data[31:29] set, there is no event. Instead `err_valid` pulses for one cycle, with `err_domain` set to the domain and `err_qid` set to data[9:0].
- R9: Kind 1 gives `ev_qid`=data[9:0], `ev_aux`=data[23:16] and `ev_count`=data[31:24]. Kind 4 gives `ev_qid`=data[9:0], `ev_flag_a`=data[14], `ev_flag_b`=data[15] and `ev_count`=data[29:16]. Kind 5 gives `ev_qid`=data[9:0], `ev_count`=data[26:16] and `ev_aux`=data[31:27]. Fields that are not named are 0.
- R10: The mailbox event (kind 9) has zero qid, count, flags and aux, and only `ev_raw` carries the word.
- R11: A write to the live dword of a listed slot with `wr_be`≠4'hF gives no event and no error. It adds one to `ign_count`, which holds at its all-ones maximum.
- R12: `ev_valid` and `err_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | 17 | Byte address: domain in bits 16:12, page offset in bits 11:0 |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte-lane enables |
| ev_valid | output | 1 | One-cycle doorbell event |
| ev_kind | output | 4 | Doorbell kind code |
| ev_domain | output | 5 | Domain of the event |
| ev_qid | output | 11 | Queue number |
| ev_count | output | 14 | Posted or popped count |
| ev_flag_a | output | 1 | Invalidate or rearm flag |
| ev_flag_b | output | 1 | Event flag |
| ev_aux | output | 8 | WRB index or segment count |
| ev_raw | output | 32 | Raw written word |
| err_valid | output | 1 | Malformed completion doorbell pulse |
| err_domain | output | 5 | Domain of the rejected doorbell |
| err_qid | output | 10 | Queue number of the rejected doorbell |
| ign_count | output | IGN_W (8) | Saturating count of partial writes |

## Verification
The bench drives every listed slot with words that set the edge bits of each field, so a design that shifts a field by one position, or uses the wrong layout for a kind, reports a wrong qid or count. It hits each reserved bit group of the completion doorbell separately. A design that checks only one group would then execute a malformed doorbell, and a design that checks too widely would reject a clean one with both flags set. It writes to a dead dword of a slot, to offsets just below and just above the listed range, and uses partial byte enables both on live dwords and elsewhere. A design that skips the dword check fires spurious events, and a design that counts too widely moves the counter on writes that must leave it alone. A reduced counter width lets the bench drive the counter to its maximum, so a design that wraps instead of saturating falls back to a small value.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int DATA_W    = 32;
    localparam int BE_W      = 4;
    localparam int KIND_W    = 4;
    localparam int NUM_KINDS = 10;
    localparam int QID_W     = 11;
    localparam int CNT_W     = 14;
    localparam int AUX_W     = 8;
    localparam int ERRQ_W    = 10;

    typedef enum logic [KIND_W-1:0] {
        KIND_RDMA_SQ  = 4'd0,
        KIND_WRB_POST = 4'd1,
        KIND_ETH_SQ   = 4'd2,
        KIND_RDMA_RQ  = 4'd3,
        KIND_DEF_PDU  = 4'd4,
        KIND_TPM_RQ   = 4'd5,
        KIND_ETH_RQ   = 4'd6,
        KIND_CQ       = 4'd7,
        KIND_MGMT     = 4'd8,
        KIND_MBOX     = 4'd9
    } dbell_kind_e;

    typedef struct packed {
        logic [QID_W-1:0] qid;
        logic [CNT_W-1:0] count;
        logic             flag_a;
        logic             flag_b;
        logic [AUX_W-1:0] aux;
    } dbell_fields_t;

    // Send-style layout: 11-bit queue, 14-bit count.
    function automatic dbell_fields_t layout_send(input logic [DATA_W-1:0] d);
        dbell_fields_t f;
        f       = '0;
        f.qid   = d[10:0];
        f.count = d[29:16];
        return f;
    endfunction

    // Work-request post: queue, index byte, count byte.
    function automatic dbell_fields_t layout_wrb(input logic [DATA_W-1:0] d);
        dbell_fields_t f;
        f       = '0;
        f.qid   = {1'b0, d[9:0]};
        f.aux   = d[23:16];
        f.count = {6'b0, d[31:24]};
        return f;
    endfunction

    // Receive layout: queue, invalidate flag, count byte.
    function automatic dbell_fields_t layout_recv(input logic [DATA_W-1:0] d);
        dbell_fields_t f;
        f        = '0;
        f.qid    = {1'b0, d[9:0]};
        f.flag_a = d[23];
        f.count  = {6'b0, d[31:24]};
        return f;
    endfunction

    // Completion layout: queue, rearm, event, 13-bit popped count.
    function automatic dbell_fields_t layout_cq(input logic [DATA_W-1:0] d);
        dbell_fields_t f;
        f        = '0;
        f.qid    = {1'b0, d[9:0]};
        f.flag_a = d[14];
        f.flag_b = d[15];
        f.count  = {1'b0, d[28:16]};
        return f;
    endfunction

    // Default-PDU layout: like completion but a 14-bit processed count.
    function automatic dbell_fields_t layout_pdu(input logic [DATA_W-1:0] d);
        dbell_fields_t f;
        f        = '0;
        f.qid    = {1'b0, d[9:0]};
        f.flag_a = d[14];
        f.flag_b = d[15];
        f.count  = d[29:16];
        return f;
    endfunction

    // Offload receive layout: queue, 11-bit count, 5-bit segment count.
    function automatic dbell_fields_t layout_tpm(input logic [DATA_W-1:0] d);
        dbell_fields_t f;
        f       = '0;
        f.qid   = {1'b0, d[9:0]};
        f.count = {3'b0, d[26:16]};
        f.aux   = {3'b0, d[31:27]};
        return f;
    endfunction

    // Any must-be-zero bit of a completion doorbell set.
    function automatic logic cq_dirty(input logic [DATA_W-1:0] d);
        return (|d[13:10]) || (|d[31:29]);
    endfunction

endpackage

// File: rtl/dbell_addr_decode.sv
module dbell_addr_decode
    import dbell_pkg::*;
#(
    parameter int DOM_W      = 5,
    parameter int PAGE_W     = 12,
    parameter int SLOT_W     = 5,
    parameter int FIRST_SLOT = 2,
    localparam int DW_ADDR_W = DOM_W + PAGE_W - 2,
    localparam int SIDX_W    = PAGE_W - SLOT_W
) (
    input  logic [DW_ADDR_W-1:0] dw_addr,
    output logic [DOM_W-1:0]     domain,
    output logic                 live,
    output logic                 listed,
    output dbell_kind_e          kind
);

    logic [SIDX_W-1:0]    slot_idx;
    logic [NUM_KINDS-1:0] hit;

    assign domain   = dw_addr[DW_ADDR_W-1 -: DOM_W];
    assign slot_idx = dw_addr[PAGE_W-3 -: SIDX_W];
    assign live     = (dw_addr[SLOT_W-3:0] == '0);

    // One comparator per doorbell slot.
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_slot
        assign hit[k] = (int'(slot_idx) == FIRST_SLOT + k);
    end

    assign listed = |hit;

    always_comb begin
        kind = KIND_RDMA_SQ;
        for (int k = 0; k < NUM_KINDS; k++) begin
            if (hit[k]) kind = dbell_kind_e'(k[KIND_W-1:0]);
        end
    end

endmodule

// File: rtl/dbell_field_extract.sv
module dbell_field_extract
    import dbell_pkg::*;
(
    input  dbell_kind_e         kind,
    input  logic [DATA_W-1:0]   data,
    output dbell_fields_t       fields,
    output logic                reserved_bad
);

    always_comb begin
        unique case (kind)
            KIND_RDMA_SQ,
            KIND_ETH_SQ,
            KIND_MGMT:     fields = layout_send(data);
            KIND_WRB_POST: fields = layout_wrb(data);
            KIND_RDMA_RQ,
            KIND_ETH_RQ:   fields = layout_recv(data);
            KIND_DEF_PDU:  fields = layout_pdu(data);
            KIND_TPM_RQ:   fields = layout_tpm(data);
            KIND_CQ:       fields = layout_cq(data);
            default:       fields = '0;
        endcase
    end

    assign reserved_bad = (kind == KIND_CQ) && cq_dirty(data);

endmodule

// File: rtl/dbell_sat_counter.sv
module dbell_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc && (count != '1)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/dbell_write_decode.sv
module dbell_write_decode
    import dbell_pkg::*;
#(
    parameter int NUM_DOM    = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int SLOT_BYTES = 32,
    parameter int FIRST_SLOT = 2,
    parameter int IGN_W      = 8,
    localparam int DOM_W     = $clog2(NUM_DOM),
    localparam int PAGE_W    = $clog2(PAGE_BYTES),
    localparam int SLOT_W    = $clog2(SLOT_BYTES),
    localparam int ADDR_W    = DOM_W + PAGE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_valid,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [BE_W-1:0]      wr_be,
    output logic                 ev_valid,
    output logic [KIND_W-1:0]    ev_kind,
    output logic [DOM_W-1:0]     ev_domain,
    output logic [QID_W-1:0]     ev_qid,
    output logic [CNT_W-1:0]     ev_count,
    output logic                 ev_flag_a,
    output logic                 ev_flag_b,
    output logic [AUX_W-1:0]     ev_aux,
    output logic [DATA_W-1:0]    ev_raw,
    output logic                 err_valid,
    output logic [DOM_W-1:0]     err_domain,
    output logic [ERRQ_W-1:0]    err_qid,
    output logic [IGN_W-1:0]     ign_count
);

    logic          unused_addr_lsb;
    logic [DOM_W-1:0] dec_domain;
    logic          dec_live;
    logic          dec_listed;
    dbell_kind_e   dec_kind;
    dbell_fields_t ext_fields;
    logic          ext_bad;

    logic          slot_access;
    logic          full_word;
    logic          fire;
    logic          reject;

    logic          ev_valid_q;
    dbell_kind_e   ev_kind_q;
    logic [DOM_W-1:0] ev_domain_q;
    dbell_fields_t ev_fields_q;
    logic [DATA_W-1:0] ev_raw_q;
    logic          err_valid_q;
    logic [DOM_W-1:0] err_domain_q;
    logic [ERRQ_W-1:0] err_qid_q;

    assign unused_addr_lsb = ^wr_addr[1:0];

    dbell_addr_decode #(
        .DOM_W      (DOM_W),
        .PAGE_W     (PAGE_W),
        .SLOT_W     (SLOT_W),
        .FIRST_SLOT (FIRST_SLOT)
    ) i_addr_decode (
        .dw_addr (wr_addr[ADDR_W-1:2]),
        .domain  (dec_domain),
        .live    (dec_live),
        .listed  (dec_listed),
        .kind    (dec_kind)
    );

    dbell_field_extract i_field_extract (
        .kind         (dec_kind),
        .data         (wr_data),
        .fields       (ext_fields),
        .reserved_bad (ext_bad)
    );

    assign slot_access = wr_valid && dec_live && dec_listed;
    assign full_word   = (wr_be == '1);
    assign fire        = slot_access && full_word;
    assign reject      = fire && ext_bad;

    dbell_sat_counter #(
        .W (IGN_W)
    ) i_ign_counter (
        .clk   (clk),
        .rst   (rst),
        .inc   (slot_access && !full_word),
        .count (ign_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_valid_q   <= 1'b0;
            ev_kind_q    <= KIND_RDMA_SQ;
            ev_domain_q  <= '0;
            ev_fields_q  <= '0;
            ev_raw_q     <= '0;
            err_valid_q  <= 1'b0;
            err_domain_q <= '0;
            err_qid_q    <= '0;
        end else begin
            ev_valid_q  <= fire && !reject;
            err_valid_q <= reject;
            if (fire && !reject) begin
                ev_kind_q   <= dec_kind;
                ev_domain_q <= dec_domain;
                ev_fields_q <= ext_fields;
                ev_raw_q    <= wr_data;
            end
            if (reject) begin
                err_domain_q <= dec_domain;
                err_qid_q    <= ext_fields.qid[ERRQ_W-1:0];
            end
        end
    end

    assign ev_valid   = ev_valid_q;
    assign ev_kind    = ev_kind_q;
    assign ev_domain  = ev_domain_q;
    assign ev_qid     = ev_fields_q.qid;
    assign ev_count   = ev_fields_q.count;
    assign ev_flag_a  = ev_fields_q.flag_a;
    assign ev_flag_b  = ev_fields_q.flag_b;
    assign ev_aux     = ev_fields_q.aux;
    assign ev_raw     = ev_raw_q;
    assign err_valid  = err_valid_q;
    assign err_domain = err_domain_q;
    assign err_qid    = err_qid_q;

endmodule

// File: rtl/dbell_write_decode_chk.sv
module dbell_write_decode_chk
    import dbell_pkg::*;
#(
    parameter int PAGE_W     = 12,
    parameter int SLOT_W     = 5,
    parameter int FIRST_SLOT = 2,
    parameter int IGN_W      = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_valid,
    input logic [PAGE_W-3:0]   wr_off_dw,
    input logic [BE_W-1:0]     wr_be,
    input logic                ev_valid,
    input logic [KIND_W-1:0]   ev_kind,
    input logic                err_valid,
    input logic [IGN_W-1:0]    ign_count
);

    logic [PAGE_W-SLOT_W-1:0] slot;
    logic                     dead_dword;
    logic                     off_list;

    assign slot       = wr_off_dw[PAGE_W-3 -: PAGE_W-SLOT_W];
    assign dead_dword = (wr_off_dw[SLOT_W-3:0] != '0);
    assign off_list   = (int'(slot) < FIRST_SLOT) || (int'(slot) >= FIRST_SLOT + NUM_KINDS);

    a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ev_valid && err_valid));

    a_r2_caused_by_write: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> $past(wr_valid));

    a_r2_kind_range: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> (int'(ev_kind) < NUM_KINDS));

    a_r3_dead_dword: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && dead_dword) |=> (!ev_valid && !err_valid));

    a_r4_reserved_offset: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && off_list) |=> (!ev_valid && !err_valid));

    a_r8_err_cause: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> $past(wr_valid && (wr_be == 4'hF)));

    a_r11_partial_drop: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && (wr_be != 4'hF)) |=> (!ev_valid && !err_valid));

    a_r11_count_monotonic: assert property (@(posedge clk) disable iff (rst)
        ign_count >= $past(ign_count));

endmodule

bind dbell_write_decode dbell_write_decode_chk #(
    .PAGE_W     (PAGE_W),
    .SLOT_W     (SLOT_W),
    .FIRST_SLOT (FIRST_SLOT),
    .IGN_W      (IGN_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_off_dw (wr_addr[PAGE_W-1:2]),
    .wr_be     (wr_be),
    .ev_valid  (ev_valid),
    .ev_kind   (ev_kind),
    .err_valid (err_valid),
    .ign_count (ign_count)
);

// File: tb/test_dbell_write_decode.sv
module test_dbell_write_decode;

    localparam int CLK_PERIOD = 10;
    localparam int IGN_W      = 3;
    localparam int NVEC       = 17;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic        ev_valid;
    logic [3:0]  ev_kind;
    logic [4:0]  ev_domain;
    logic [10:0] ev_qid;
    logic [13:0] ev_count;
    logic        ev_flag_a;
    logic        ev_flag_b;
    logic [7:0]  ev_aux;
    logic [31:0] ev_raw;
    logic        err_valid;
    logic [4:0]  err_domain;
    logic [9:0]  err_qid;
    logic [IGN_W-1:0] ign_count;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int exp_ign = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbell_write_decode #(.IGN_W(IGN_W)) i_dbell_write_decode (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .ev_valid(ev_valid),
        .ev_kind(ev_kind), .ev_domain(ev_domain), .ev_qid(ev_qid),
        .ev_count(ev_count), .ev_flag_a(ev_flag_a), .ev_flag_b(ev_flag_b),
        .ev_aux(ev_aux), .ev_raw(ev_raw), .err_valid(err_valid),
        .err_domain(err_domain), .err_qid(err_qid), .ign_count(ign_count)
    );

    // {addr, data, be, expect_event, expect_error}
    localparam logic [54:0] VEC [0:NVEC-1] = '{
        {17'h00040, 32'h2ABC07FF, 4'hF, 1'b1, 1'b0},
        {17'h05060, 32'h12345678, 4'hF, 1'b1, 1'b0},
        {17'h1F080, 32'hFFFFFFFF, 4'hF, 1'b1, 1'b0},
        {17'h020A0, 32'h80800155, 4'hF, 1'b1, 1'b0},
        {17'h030C0, 32'h3FFFC3FF, 4'hF, 1'b1, 1'b0},
        {17'h040E0, 32'hFFFF0001, 4'hF, 1'b1, 1'b0},
        {17'h06100, 32'h01000200, 4'hF, 1'b1, 1'b0},
        {17'h07120, 32'h1FFFC3FF, 4'hF, 1'b1, 1'b0},
        {17'h07120, 32'h00000401, 4'hF, 1'b0, 1'b1},
        {17'h08120, 32'h20000005, 4'hF, 1'b0, 1'b1},
        {17'h09140, 32'h00050123, 4'hF, 1'b1, 1'b0},
        {17'h0A160, 32'hDEADBEEF, 4'hF, 1'b1, 1'b0},
        {17'h01044, 32'h00010001, 4'hF, 1'b0, 1'b0},
        {17'h01020, 32'h00010001, 4'hF, 1'b0, 1'b0},
        {17'h01180, 32'h00010001, 4'hF, 1'b0, 1'b0},
        {17'h017FC, 32'h00010001, 4'hF, 1'b0, 1'b0},
        {17'h0B043, 32'h00000001, 4'hF, 1'b1, 1'b0}
    };

    typedef struct packed {
        logic [10:0] qid;
        logic [13:0] cnt;
        logic        fa;
        logic        fb;
        logic [7:0]  aux;
    } exp_f_t;

    function automatic exp_f_t model_fields(input logic [3:0] k, input logic [31:0] d);
        exp_f_t f;
        f = '0;
        case (k)
            4'd0, 4'd2, 4'd8: begin f.qid = d[10:0]; f.cnt = d[29:16]; end
            4'd1: begin f.qid = {1'b0, d[9:0]}; f.aux = d[23:16]; f.cnt = {6'b0, d[31:24]}; end
            4'd3, 4'd6: begin f.qid = {1'b0, d[9:0]}; f.fa = d[23]; f.cnt = {6'b0, d[31:24]}; end
            4'd4: begin f.qid = {1'b0, d[9:0]}; f.fa = d[14]; f.fb = d[15]; f.cnt = d[29:16]; end
            4'd5: begin f.qid = {1'b0, d[9:0]}; f.cnt = {3'b0, d[26:16]}; f.aux = {3'b0, d[31:27]}; end
            4'd7: begin f.qid = {1'b0, d[9:0]}; f.fa = d[14]; f.fb = d[15]; f.cnt = {1'b0, d[28:16]}; end
            default: f = '0;
        endcase
        return f;
    endfunction

    function automatic string layout_req(input logic [3:0] k);
        case (k)
            4'd0, 4'd2, 4'd8: return "R5";
            4'd3, 4'd6:       return "R6";
            4'd7:             return "R7";
            4'd9:             return "R10";
            default:          return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Counter model for a single write, per the partial-write rule.
    task automatic track_ign(input logic [16:0] a, input logic [3:0] b);
        int s;
        s = int'(a[11:5]);
        if (a[4:2] == 3'd0 && s >= 2 && s <= 11 && b != 4'hF && exp_ign < 7)
            exp_ign++;
    endtask

    task automatic wr(input logic [16:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        wr_be    = b;
        @(negedge clk);
        wr_valid = 1'b0;
        wr_be    = 4'h0;
        track_ign(a, b);
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1", "ev_valid in reset", 32'(ev_valid), 0);
        chk("R1", "err_valid in reset", 32'(err_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ev_valid after reset", 32'(ev_valid), 0);
        chk("R1", "err_valid after reset", 32'(err_valid), 0);
        chk("R1", "ign_count after reset", 32'(ign_count), 0);
        chk("R1", "ev_kind after reset", 32'(ev_kind), 0);
        chk("R1", "ev_raw after reset", ev_raw, 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [16:0] a;
            logic [31:0] d;
            logic [3:0]  b;
            logic        xe, xr;
            logic [3:0]  k;
            exp_f_t      f;
            string       rq;
            {a, d, b, xe, xr} = VEC[i];
            k  = 4'(a[11:5] - 7'd2);
            rq = (a[4:2] != 3'd0) ? "R3" : ((a[11:5] < 7'd2 || a[11:5] > 7'd11) ? "R4" : "R2");
            wr(a, d, b);
            chk(xr ? "R8" : rq, "ev_valid", 32'(ev_valid), 32'(xe));
            chk(xr ? "R8" : rq, "err_valid", 32'(err_valid), 32'(xr));
            chk("R12", "ev and err together", 32'(ev_valid && err_valid), 0);
            if (xe) begin
                f = model_fields(k, d);
                chk("R2", "ev_kind", 32'(ev_kind), 32'(k));
                chk("R2", "ev_domain", 32'(ev_domain), 32'(a[16:12]));
                chk("R2", "ev_raw", ev_raw, d);
                chk(layout_req(k), "ev_qid", 32'(ev_qid), 32'(f.qid));
                chk(layout_req(k), "ev_count", 32'(ev_count), 32'(f.cnt));
                chk(layout_req(k), "ev_flag_a", 32'(ev_flag_a), 32'(f.fa));
                chk(layout_req(k), "ev_flag_b", 32'(ev_flag_b), 32'(f.fb));
                chk(layout_req(k), "ev_aux", 32'(ev_aux), 32'(f.aux));
                // R2 single-cycle pulse
                @(negedge clk);
                chk("R2", "ev_valid drops after one cycle", 32'(ev_valid), 0);
            end
            if (xr) begin
                chk("R8", "err_domain", 32'(err_domain), 32'(a[16:12]));
                chk("R8", "err_qid", 32'(err_qid), 32'(d[9:0]));
                @(negedge clk);
                chk("R8", "err_valid drops after one cycle", 32'(err_valid), 0);
            end
            chk(rq, "ign_count unchanged by full writes", 32'(ign_count), 0);
        end

        // R2 back-to-back writes on consecutive cycles
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 17'h0C100; wr_data = 32'h05000011; wr_be = 4'hF;
        @(negedge clk);
        wr_addr = 17'h0D040; wr_data = 32'h00220033;
        chk("R2", "back-to-back first valid", 32'(ev_valid), 1);
        chk("R6", "back-to-back first qid", 32'(ev_qid), 32'h011);
        chk("R6", "back-to-back first count", 32'(ev_count), 32'h05);
        @(negedge clk);
        wr_valid = 1'b0; wr_be = 4'h0;
        chk("R2", "back-to-back second valid", 32'(ev_valid), 1);
        chk("R2", "back-to-back second domain", 32'(ev_domain), 32'h0D);
        chk("R5", "back-to-back second qid", 32'(ev_qid), 32'h033);
        chk("R5", "back-to-back second count", 32'(ev_count), 32'h22);

        // R11 partial byte enables on live dwords
        wr(17'h00040, 32'h00010001, 4'h7);
        chk("R11", "partial write no event", 32'(ev_valid), 0);
        chk("R11", "ign_count after first partial", 32'(ign_count), 32'(exp_ign));
        wr(17'h07120, 32'h00000401, 4'hE);
        chk("R11", "partial dirty cq no error", 32'(err_valid), 0);
        chk("R11", "ign_count after second partial", 32'(ign_count), 32'(exp_ign));
        // R4 partial on a reserved offset is not counted
        wr(17'h01020, 32'h00000001, 4'h3);
        chk("R4", "partial reserved offset not counted", 32'(ign_count), 32'(exp_ign));
        // R3 partial on a dead dword is not counted
        wr(17'h01048, 32'h00000001, 4'h1);
        chk("R3", "partial dead dword not counted", 32'(ign_count), 32'(exp_ign));
        // R11 saturation
        for (int j = 0; j < 8; j++) wr(17'h00160, 32'h0, 4'h0);
        chk("R11", "ign_count saturates", 32'(ign_count), 7);
        chk("R11", "ign_count model at max", 32'(exp_ign), 7);
        // events still work after saturation
        wr(17'h1E120, 32'h0003C005, 4'hF);
        chk("R7", "cq after saturation valid", 32'(ev_valid), 1);
        chk("R7", "cq rearm", 32'(ev_flag_a), 1);
        chk("R7", "cq event flag", 32'(ev_flag_b), 1);
        chk("R7", "cq count", 32'(ev_count), 32'h3);
        chk("R11", "ign_count holds", 32'(ign_count), 7);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule